// File: doc/BRIEF.md
# Idle and Power-Down Controller

This block holds an 8-bit power control register, decoded at address 87h, and turns its contents into clock-enable and pin-override controls for a small microcontroller core. Setting the idle bit stops the core clock but leaves the peripheral clocks (timers, serial port, interrupt logic) running. Setting the power-down bit stops the oscillator and every clock derived from it. A mode ends in one of two ways. Idle ends on an enabled pending interrupt or on a qualified hardware reset. Power-down ends only on a qualified hardware reset.

The register also carries a baud-rate doubling bit and two general-purpose flags, which have no side effects. The raw hardware reset request counts as a reset only once it has been seen high on 24 consecutive oscillator clocks, which is two machine cycles of 12 clocks each. While a low-power mode is active, the block tells the pad logic how to treat the bus pins. The two bus strobes are forced to one level. The low address/data bus floats. The high address bus either keeps the fetch address or returns to its port latch. The host side writes the register with a one-cycle write strobe and reads it back continuously.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the synchronous active-low reset `rst_n`, `rd_data` is 00h, and `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 1. `rst_out` is 0.
- R2: In run mode, a write to address 87h stores the written byte, with bits 6:4 forced to 0. Bit 7 appears on `baud_double` and bits 3:2 on `user_flags`. A write to any other address leaves `rd_data` unchanged.
- R3: After an edge that stores bit 0 = 1 with bit 1 = 0 (idle), `cpu_clk_en` is 0 from that edge on, while `periph_clk_en` and `osc_en` stay 1.
- R4: After an edge that stores bit 1 = 1 (power-down), `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0. This holds even when bit 0 is written to 1 in the same byte: power-down takes precedence.
- R5: In idle, an edge that samples `irq_pending` = 1 clears bit 0 and raises `cpu_clk_en` again. All other register bits are kept.
- R6: If `irq_pending` is already 1 on the edge that writes the idle bit, idle is entered for exactly one cycle and left on the next edge.
- R7: In power-down, `irq_pending` has no effect on the register or on the clock enables.
- R8: When `hw_reset_req` is sampled high on 24 consecutive edges, the 24th edge clears the register and ends any mode, and `rst_out` is 1 from that edge until the request drops. A run of 23 consecutive high edges changes nothing.
- R9: While idle or power-down is active, register writes are ignored.
- R10: In either low-power mode, `strobe_ovr` is 1. `strobe_lvl` is 1 in idle and 0 in power-down. `lo_bus_float` is 1 when `fetch_external` is 1. `hi_bus_addr` is 1 only in idle with `fetch_external` = 1. In run mode all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_reset_req | input | 1 | Raw hardware reset request, active high, needs qualification |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_pending | input | 1 | An enabled interrupt is pending |
| fetch_external | input | 1 | Core executes from external program memory |
| rd_data | output | 8 | Current register contents |
| baud_double | output | 1 | Baud-rate doubling bit (bit 7) |
| user_flags | output | 2 | General-purpose flags (bits 3:2) |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator run enable |
| rst_out | output | 1 | Qualified reset |
| strobe_ovr | output | 1 | Bus strobes forced by a low-power mode |
| strobe_lvl | output | 1 | Level of forced strobes |
| lo_bus_float | output | 1 | Low address/data bus floats |
| hi_bus_addr | output | 1 | High bus keeps the fetch address |

## Verification
The bound checker watches several rules on every cycle. Clock enables must agree with the stored mode bits. An interrupt seen in idle must wake the core on the next edge. Power-down must persist unless a reset request is present. Writes made during a low-power mode must leave the register stable. A qualified reset must hold the register clear, and the pin overrides must match the mode. Some behaviour shows only in the bench's scenarios against its reference model. These are the exact 23-versus-24 edge boundary of reset qualification, the one-cycle idle when a write and an interrupt coincide, byte masking of the reserved bits, address decoding, and the reset state.

// File: rtl/pwr_mode_pkg.sv
// Package: shared bit positions, mode type and mode decode for the
// power-mode controller. Assumes an 8-bit control register.
package pwr_mode_pkg;
    localparam int REG_W   = 8;
    localparam int IDL_BIT = 0;
    localparam int PD_BIT  = 1;
    localparam int GF_LO   = 2;
    localparam int GF_HI   = 3;
    localparam int BD_BIT  = 7;
    localparam logic [REG_W-1:0] KEEP_MASK =
        (REG_W'(1) << BD_BIT) | (REG_W'(1) << GF_HI) | (REG_W'(1) << GF_LO) |
        (REG_W'(1) << PD_BIT) | (REG_W'(1) << IDL_BIT);

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pm_mode_t;

    // Power-down wins over idle when both bits are set.
    function automatic pm_mode_t decode_mode(input logic idl, input logic pd);
        if (pd)       return PM_DOWN;
        else if (idl) return PM_IDLE;
        else          return PM_RUN;
    endfunction
endpackage

// File: rtl/pwr_rst_qual.sv
// Reset qualifier: counts consecutive clocks with the raw request high and
// flags a reset once QUAL_CYC of them have been seen. Assumes clk is the
// free-running oscillator clock seen by this block.
module pwr_rst_qual #(
    parameter int QUAL_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic qual_now,
    output logic rst_out
);
    localparam int CNT_W = $clog2(QUAL_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(QUAL_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYC - 1);

    logic [CNT_W-1:0] run_cnt;

    // This edge is the QUAL_CYC-th consecutive high sample.
    assign qual_now = req && (run_cnt >= CNT_LAST);

    // Count consecutive high samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_cnt <= '0;
        else if (!req)              run_cnt <= '0;
        else if (run_cnt < CNT_MAX) run_cnt <= run_cnt + 1'b1;
    end

    // Registered qualified reset, held while the request stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_out <= 1'b0;
        else        rst_out <= qual_now;
    end
endmodule

// File: rtl/pwr_ctl_reg.sv
// Control register: host writes in run mode, hardware clear of the idle
// bit on interrupt, full clear on qualified reset. Exposes both the stored
// value and its next value. Assumes the host cannot write while the core
// clock is stopped, so such writes are dropped.
module pwr_ctl_reg
    import pwr_mode_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              irq_pending,
    output logic [REG_W-1:0]  reg_q,
    output logic [REG_W-1:0]  reg_d
);
    pm_mode_t mode;
    logic     wr_hit;

    assign mode   = decode_mode(reg_q[IDL_BIT], reg_q[PD_BIT]);
    assign wr_hit = wr_en && (wr_addr == REG_ADDR);

    // Next-value selection: reset clear, then per-mode update.
    always_comb begin
        reg_d = reg_q;
        if (clr) begin
            reg_d = '0;
        end else begin
            case (mode)
                PM_RUN:  if (wr_hit) reg_d = wr_data & KEEP_MASK;
                PM_IDLE: if (irq_pending) reg_d[IDL_BIT] = 1'b0;
                default: ;
            endcase
        end
    end

    // Register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end
endmodule

// File: rtl/pwr_clk_gate.sv
// Clock-enable and pin-override generation. Enables are registered from
// the register's next value so they change only on a clock edge, in step
// with the stored bits. Overrides decode the stored bits.
module pwr_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic idl_d,
    input  logic pd_d,
    input  logic idl_q,
    input  logic pd_q,
    input  logic fetch_external,
    output logic cpu_clk_en,
    output logic periph_clk_en,
    output logic osc_en,
    output logic strobe_ovr,
    output logic strobe_lvl,
    output logic lo_bus_float,
    output logic hi_bus_addr
);
    logic low_pwr;
    logic idle_only;

    // Glitch-free enables from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_clk_en    <= 1'b1;
            periph_clk_en <= 1'b1;
            osc_en        <= 1'b1;
        end else begin
            cpu_clk_en    <= !(idl_d || pd_d);
            periph_clk_en <= !pd_d;
            osc_en        <= !pd_d;
        end
    end

    // Pad overrides per mode.
    always_comb begin
        low_pwr      = idl_q || pd_q;
        idle_only    = idl_q && !pd_q;
        strobe_ovr   = low_pwr;
        strobe_lvl   = idle_only;
        lo_bus_float = low_pwr && fetch_external;
        hi_bus_addr  = idle_only && fetch_external;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top of the idle/power-down controller: reset qualifier, control
// register and clock/override generation. Assumes clk keeps toggling in
// the model; osc_en tells the oscillator to stop.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h87,
    parameter int                OSC_PER_MC = 12,
    parameter int                RST_MC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_reset_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              irq_pending,
    input  logic              fetch_external,
    output logic [7:0]        rd_data,
    output logic              baud_double,
    output logic [1:0]        user_flags,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              osc_en,
    output logic              rst_out,
    output logic              strobe_ovr,
    output logic              strobe_lvl,
    output logic              lo_bus_float,
    output logic              hi_bus_addr
);
    localparam int QUAL_CYC = OSC_PER_MC * RST_MC;

    logic             qual_now;
    logic [REG_W-1:0] reg_q;
    logic [REG_W-1:0] reg_d;

    pwr_rst_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (hw_reset_req),
        .qual_now (qual_now),
        .rst_out  (rst_out)
    );

    pwr_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (qual_now),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .irq_pending (irq_pending),
        .reg_q       (reg_q),
        .reg_d       (reg_d)
    );

    pwr_clk_gate u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .idl_d          (reg_d[IDL_BIT]),
        .pd_d           (reg_d[PD_BIT]),
        .idl_q          (reg_q[IDL_BIT]),
        .pd_q           (reg_q[PD_BIT]),
        .fetch_external (fetch_external),
        .cpu_clk_en     (cpu_clk_en),
        .periph_clk_en  (periph_clk_en),
        .osc_en         (osc_en),
        .strobe_ovr     (strobe_ovr),
        .strobe_lvl     (strobe_lvl),
        .lo_bus_float   (lo_bus_float),
        .hi_bus_addr    (hi_bus_addr)
    );

    // Register fields to the outside.
    assign rd_data     = reg_q;
    assign baud_double = reg_q[BD_BIT];
    assign user_flags  = reg_q[GF_HI:GF_LO];
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Checker for the power-mode controller, bound to the top module. Relates
// the stored register, clock enables, reset and override outputs.
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_reset_req,
    input logic       irq_pending,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic       osc_en,
    input logic       rst_out,
    input logic       strobe_ovr,
    input logic       strobe_lvl,
    input logic       hi_bus_addr
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:4] == 3'b000);

    // R3
    idle_gates_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !rd_data[1]) |-> (!cpu_clk_en && periph_clk_en && osc_en));

    // R4
    pd_stops_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] |-> (!cpu_clk_en && !periph_clk_en && !osc_en));

    // R5
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !rd_data[1] && irq_pending) |=> (!rd_data[0] && cpu_clk_en));

    // R7
    pd_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1] && !hw_reset_req) |=> rd_data[1]);

    // R8
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> (rd_data == 8'h00 && cpu_clk_en && osc_en));

    // R8
    rst_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(hw_reset_req));

    // R9
    write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && wr_en && !irq_pending && !hw_reset_req) |=> $stable(rd_data));

    // R10
    strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ovr |-> !cpu_clk_en) and ((strobe_ovr && !osc_en) |-> !strobe_lvl));

    // R10
    hi_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_bus_addr |-> (osc_en && !cpu_clk_en));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_reset_req  (hw_reset_req),
    .irq_pending   (irq_pending),
    .wr_en         (wr_en),
    .rd_data       (rd_data),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .rst_out       (rst_out),
    .strobe_ovr    (strobe_ovr),
    .strobe_lvl    (strobe_lvl),
    .hi_bus_addr   (hi_bus_addr)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int QUAL = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_reset_req = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       irq_pending = 1'b0;
    logic       fetch_external = 1'b0;

    logic [7:0] rd_data;
    logic       baud_double;
    logic [1:0] user_flags;
    logic       cpu_clk_en, periph_clk_en, osc_en, rst_out;
    logic       strobe_ovr, strobe_lvl, lo_bus_float, hi_bus_addr;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_reset_req(hw_reset_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_pending(irq_pending), .fetch_external(fetch_external),
        .rd_data(rd_data), .baud_double(baud_double), .user_flags(user_flags),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .rst_out(rst_out), .strobe_ovr(strobe_ovr), .strobe_lvl(strobe_lvl),
        .lo_bus_float(lo_bus_float), .hi_bus_addr(hi_bus_addr)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    // Behavioural reference model.
    logic [7:0] m_reg = 8'h00;
    int         m_run = 0;
    bit         m_rst = 1'b0;
    bit         m_qual;

    always @(posedge clk) begin : ref_model
        if (!rst_n) begin
            m_reg = 8'h00; m_run = 0; m_rst = 1'b0;
        end else begin
            m_qual = hw_reset_req && (m_run >= QUAL - 1);
            if (!hw_reset_req)   m_run = 0;
            else if (m_run < QUAL) m_run = m_run + 1;
            m_rst = m_qual;
            if (m_qual)          m_reg = 8'h00;
            else if (m_reg[1])   ;
            else if (m_reg[0])   begin if (irq_pending) m_reg[0] = 1'b0; end
            else if (wr_en && wr_addr == 8'h87) m_reg = wr_data & 8'h8F;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin : cmp_model
        if (cmp_on) begin
            chk(cur_req, "rd_data", rd_data, m_reg);
            chk(cur_req, "baud_double", {7'd0, baud_double}, {7'd0, m_reg[7]});
            chk(cur_req, "user_flags", {6'd0, user_flags}, {6'd0, m_reg[3:2]});
            chk(cur_req, "cpu_clk_en", {7'd0, cpu_clk_en}, {7'd0, !(m_reg[0] || m_reg[1])});
            chk(cur_req, "periph_clk_en", {7'd0, periph_clk_en}, {7'd0, !m_reg[1]});
            chk(cur_req, "osc_en", {7'd0, osc_en}, {7'd0, !m_reg[1]});
            chk(cur_req, "rst_out", {7'd0, rst_out}, {7'd0, m_rst});
            chk(cur_req, "strobe_ovr", {7'd0, strobe_ovr}, {7'd0, m_reg[0] || m_reg[1]});
            chk(cur_req, "strobe_lvl", {7'd0, strobe_lvl}, {7'd0, m_reg[0] && !m_reg[1]});
            chk(cur_req, "lo_bus_float", {7'd0, lo_bus_float},
                {7'd0, (m_reg[0] || m_reg[1]) && fetch_external});
            chk(cur_req, "hi_bus_addr", {7'd0, hi_bus_addr},
                {7'd0, m_reg[0] && !m_reg[1] && fetch_external});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic hold_reset_req(input int n);
        hw_reset_req = 1'b1;
        tick(n);
        hw_reset_req = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin : stimulus
        tick(3);
        cmp_on = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset rd_data", rd_data, 8'h00);
        chk("R1", "reset enables", {5'd0, cpu_clk_en, periph_clk_en, osc_en}, 8'h07);
        rst_n = 1'b1;
        tick(2);

        // R2 write with reserved bits, other address ignored
        cur_req = "R2";
        write_reg(8'h87, 8'hFC);
        @(negedge clk);
        chk("R2", "masked write", rd_data, 8'h8C);
        chk("R2", "flags", {5'd0, baud_double, user_flags}, 8'h07);
        tick(1);
        write_reg(8'h86, 8'h00);
        @(negedge clk);
        chk("R2", "other address ignored", rd_data, 8'h8C);
        tick(1);
        write_reg(8'h87, 8'h04);

        // R3 idle gates only the core clock
        cur_req = "R3";
        write_reg(8'h87, 8'h05);
        @(negedge clk);
        chk("R3", "idle enables", {5'd0, cpu_clk_en, periph_clk_en, osc_en}, 8'h03);
        tick(5);

        // R9 write ignored in idle
        cur_req = "R9";
        write_reg(8'h87, 8'h80);
        @(negedge clk);
        chk("R9", "idle write ignored", rd_data, 8'h05);
        tick(1);

        // R5 interrupt wakes idle, flags kept
        cur_req = "R5";
        irq_pending = 1'b1;
        tick(1);
        irq_pending = 1'b0;
        @(negedge clk);
        chk("R5", "wake register", rd_data, 8'h04);
        chk("R5", "wake cpu enable", {7'd0, cpu_clk_en}, 8'h01);
        tick(2);

        // R6 interrupt already pending on the idle write
        cur_req = "R6";
        irq_pending = 1'b1;
        write_reg(8'h87, 8'h01);
        @(negedge clk);
        chk("R6", "one idle cycle", {7'd0, cpu_clk_en}, 8'h00);
        tick(1);
        @(negedge clk);
        chk("R6", "left idle", {7'd0, cpu_clk_en}, 8'h01);
        irq_pending = 1'b0;
        tick(2);

        // R4 both bits written: power-down wins
        cur_req = "R4";
        write_reg(8'h87, 8'h03);
        @(negedge clk);
        chk("R4", "pd enables", {5'd0, cpu_clk_en, periph_clk_en, osc_en}, 8'h00);
        tick(3);

        // R7 interrupt ignored in power-down
        cur_req = "R7";
        irq_pending = 1'b1;
        tick(6);
        irq_pending = 1'b0;
        @(negedge clk);
        chk("R7", "pd kept", rd_data, 8'h03);

        // R9 write ignored in power-down
        cur_req = "R9";
        tick(1);
        write_reg(8'h87, 8'h00);
        @(negedge clk);
        chk("R9", "pd write ignored", rd_data, 8'h03);

        // R8 23 edges are not enough, 24 clear
        cur_req = "R8";
        tick(1);
        hold_reset_req(23);
        @(negedge clk);
        chk("R8", "23 edges no reset", rd_data, 8'h03);
        chk("R8", "23 edges rst_out", {7'd0, rst_out}, 8'h00);
        tick(2);
        hw_reset_req = 1'b1;
        tick(24);
        @(negedge clk);
        chk("R8", "24 edges clear", rd_data, 8'h00);
        chk("R8", "24 edges rst_out", {7'd0, rst_out}, 8'h01);
        chk("R8", "24 edges osc", {7'd0, osc_en}, 8'h01);
        tick(3);
        hw_reset_req = 1'b0;
        tick(1);
        @(negedge clk);
        chk("R8", "rst_out drops", {7'd0, rst_out}, 8'h00);
        tick(1);

        // R8 reset also ends idle
        write_reg(8'h87, 8'h09);
        tick(2);
        hold_reset_req(24);
        @(negedge clk);
        chk("R8", "reset ends idle", {7'd0, cpu_clk_en}, 8'h01);
        tick(2);

        // R10 pin overrides in each mode
        cur_req = "R10";
        fetch_external = 1'b1;
        @(negedge clk);
        chk("R10", "run overrides", {4'd0, strobe_ovr, strobe_lvl, lo_bus_float, hi_bus_addr}, 8'h00);
        tick(1);
        write_reg(8'h87, 8'h01);
        @(negedge clk);
        chk("R10", "idle overrides", {4'd0, strobe_ovr, strobe_lvl, lo_bus_float, hi_bus_addr}, 8'h0F);
        tick(1);
        irq_pending = 1'b1;
        tick(1);
        irq_pending = 1'b0;
        write_reg(8'h87, 8'h02);
        @(negedge clk);
        chk("R10", "pd overrides", {4'd0, strobe_ovr, strobe_lvl, lo_bus_float, hi_bus_addr}, 8'h0A);
        tick(1);
        fetch_external = 1'b0;
        tick(1);
        hold_reset_req(24);
        tick(3);

        done = 1'b1;
        cmp_on = 1'b0;
        summary();
        $finish;
    end
endmodule